// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block guesses the next fetch address from nothing but the current program counter, in the same cycle the counter is presented. It is a direct-mapped table in which every slot holds a valid flag, a tag made of the upper PC bits, and a target address. Fetch hands it the PC. When the slot selected by the middle PC bits is valid and its tag agrees with the PC, the stored target comes back with a hit flag. In every other case the block returns the sequential address, PC plus the instruction size.

The table is written only when a control-flow instruction resolves. A conditional branch or a direct jump is stored together with its PC-relative target, so once it has been seen it is always predicted taken. Plain instructions never take a slot, and neither do register-indirect jumps, whose target is not fixed. When two branches share a slot, the more recent write replaces both the tag and the target.

Top module: `branch_tgt_buf`

## Requirements
- R1: While reset is asserted, and after it until the first insertion, every lookup misses (pred_hit = 0). Reset clears every slot.
- R2: The slot index is fetch_pc[OFS_W+IDX_W-1:OFS_W] (bits 7:2 by default). The tag is every PC bit above the index.
- R3: A lookup that finds its slot valid with an equal tag drives pred_hit = 1 and pred_pc = the stored target. The target's low OFS_W bits read as zero when DROP_TGT_OFS = 1.
- R4: On a miss, pred_hit = 0 and pred_pc = fetch_pc + INSN_BYTES, modulo 2^PC_W.
- R5: An update is written only when upd_en = 1 and upd_kind is 2'b01 (conditional branch) or 2'b10 (direct jump). Kind 2'b00 (plain instruction) and kind 2'b11 (register-indirect jump) change no slot.
- R6: An insertion into an occupied slot with a different tag replaces both tag and target. The earlier PC then misses and the new PC hits.
- R7: An insertion takes effect at the clock edge. A lookup of that same slot in the cycle of the update still returns the slot's old contents.
- R8: PC bits below the index (the byte offset) take no part in the match. Two PCs that differ only there both hit the same slot.
- R9: An insertion leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | 1 when the prediction came from a stored slot |
| upd_en | input | 1 | Resolved instruction present on the update port |
| upd_kind | input | 2 | 00 plain, 01 conditional branch, 10 direct jump, 11 register-indirect jump |
| upd_pc | input | PC_W | Address of the resolved instruction |
| upd_target | input | PC_W | Resolved PC-relative target |

## Verification
The bench goes after slot aliasing: PCs that share an index but not a tag. A design that wrote only the target, or compared too few tag bits, would hand the new target to the old branch. It drives a lookup and a write to the same slot in the same cycle, where a write-through read path would hit one cycle early. Plain and indirect updates are mixed in among the real ones; a decoder that let them through would make those PCs hit. Fetch addresses carry random byte-offset bits and one sits at the top of the address space. A design that folded the offset into the index or tag would miss those lookups, and one that saturated the increment instead of wrapping would give a wrong sequential address.

// File: rtl/btbt_pkg.sv
package btbt_pkg;

   // Kind code carried with a resolved instruction on the update port.
   typedef enum logic [1:0] {
      KIND_PLAIN    = 2'b00,
      KIND_COND     = 2'b01,
      KIND_DIRECT   = 2'b10,
      KIND_INDIRECT = 2'b11
   } cf_kind_e;

   // Only instructions with a fixed PC-relative target may occupy a slot.
   function automatic logic kind_is_storable(cf_kind_e k);
      return (k == KIND_COND) || (k == KIND_DIRECT);
   endfunction

endpackage

// File: rtl/btbt_split.sv
module btbt_split #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 6,
   parameter int OFS_W = 2,
   localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);

   // Byte-offset bits are dropped; the middle bits select the slot.
   always_comb begin
      idx = pc[OFS_W +: IDX_W];
      tag = pc[PC_W-1 -: TAG_W];
   end

endmodule

// File: rtl/btbt_entries.sv
module btbt_entries #(
   parameter int IDX_W = 6,
   parameter int TAG_W = 24,
   parameter int TGT_W = 30,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [TGT_W-1:0] wr_tgt,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [TGT_W-1:0] rd_tgt
);

   logic [DEPTH-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [TGT_W-1:0] tgt_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      // Only the valid flag needs reset; payload is qualified by it.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
         end else if (sel) begin
            valid_q[e] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[e] <= wr_tag;
            tgt_q[e] <= wr_tgt;
         end
      end
   end

   // Registered storage read combinationally: a same-cycle write is
   // not visible until after the edge.
   always_comb begin
      rd_valid = valid_q[rd_idx];
      rd_tag   = tag_q[rd_idx];
      rd_tgt   = tgt_q[rd_idx];
   end

endmodule

// File: rtl/btbt_select.sv
module btbt_select #(
   parameter int PC_W         = 32,
   parameter int OFS_W        = 2,
   parameter int TAG_W        = 24,
   parameter int TGT_W        = 30,
   parameter int INSN_BYTES   = 4,
   parameter bit DROP_TGT_OFS = 1'b1
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [TAG_W-1:0] pc_tag,
   input  logic             slot_valid,
   input  logic [TAG_W-1:0] slot_tag,
   input  logic [TGT_W-1:0] slot_tgt,
   output logic             hit,
   output logic [PC_W-1:0]  next_pc
);

   logic [PC_W-1:0] full_tgt;
   logic [PC_W-1:0] seq_pc;

   if (DROP_TGT_OFS) begin : g_tgt_compact
      assign full_tgt = {slot_tgt, {OFS_W{1'b0}}};
   end else begin : g_tgt_full
      assign full_tgt = slot_tgt;
   end

   always_comb begin
      seq_pc  = pc + PC_W'(INSN_BYTES);
      hit     = slot_valid && (slot_tag == pc_tag);
      next_pc = hit ? full_tgt : seq_pc;
   end

endmodule

// File: rtl/branch_tgt_buf.sv
module branch_tgt_buf #(
   parameter int PC_W         = 32,
   parameter int IDX_W        = 6,
   parameter int OFS_W        = 2,
   parameter int INSN_BYTES   = 4,
   parameter bit DROP_TGT_OFS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] pred_pc,
   output logic            pred_hit,
   input  logic            upd_en,
   input  logic [1:0]      upd_kind,
   input  logic [PC_W-1:0] upd_pc,
   input  logic [PC_W-1:0] upd_target
);
   import btbt_pkg::*;

   localparam int TAG_W = PC_W - IDX_W - OFS_W;
   localparam int TGT_W = DROP_TGT_OFS ? (PC_W - OFS_W) : PC_W;

   // Elaboration-time parameter checks.
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("branch_tgt_buf: IDX_W must lie in 1..12");
   end
   if (OFS_W < 0 || TAG_W < 1) begin : g_bad_split
      $error("branch_tgt_buf: OFS_W + IDX_W must leave at least one tag bit");
   end
   if (INSN_BYTES < 1) begin : g_bad_step
      $error("branch_tgt_buf: INSN_BYTES must be positive");
   end
   if (DROP_TGT_OFS && OFS_W < 1) begin : g_bad_drop
      $error("branch_tgt_buf: DROP_TGT_OFS needs OFS_W >= 1");
   end

   logic [IDX_W-1:0] look_idx, wr_idx;
   logic [TAG_W-1:0] look_tag, wr_tag;
   logic             slot_valid;
   logic [TAG_W-1:0] slot_tag;
   logic [TGT_W-1:0] slot_tgt;
   logic [TGT_W-1:0] wr_tgt;
   logic             wr_en;

   btbt_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_split_look (
      .pc (fetch_pc),
      .idx(look_idx),
      .tag(look_tag)
   );

   btbt_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_split_upd (
      .pc (upd_pc),
      .idx(wr_idx),
      .tag(wr_tag)
   );

   assign wr_en = upd_en && kind_is_storable(cf_kind_e'(upd_kind));

   if (DROP_TGT_OFS) begin : g_wr_compact
      assign wr_tgt = upd_target[PC_W-1:OFS_W];
   end else begin : g_wr_full
      assign wr_tgt = upd_target;
   end

   btbt_entries #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_entries (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_tgt  (wr_tgt),
      .rd_idx  (look_idx),
      .rd_valid(slot_valid),
      .rd_tag  (slot_tag),
      .rd_tgt  (slot_tgt)
   );

   btbt_select #(
      .PC_W(PC_W), .OFS_W(OFS_W), .TAG_W(TAG_W), .TGT_W(TGT_W),
      .INSN_BYTES(INSN_BYTES), .DROP_TGT_OFS(DROP_TGT_OFS)
   ) u_select (
      .pc        (fetch_pc),
      .pc_tag    (look_tag),
      .slot_valid(slot_valid),
      .slot_tag  (slot_tag),
      .slot_tgt  (slot_tgt),
      .hit       (pred_hit),
      .next_pc   (pred_pc)
   );

endmodule

// File: rtl/btbt_checker.sv
module btbt_checker #(
   parameter int PC_W         = 32,
   parameter int IDX_W        = 6,
   parameter int OFS_W        = 2,
   parameter int INSN_BYTES   = 4,
   parameter bit DROP_TGT_OFS = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [PC_W-1:0] pred_pc,
   input logic            pred_hit,
   input logic            upd_en,
   input logic [1:0]      upd_kind,
   input logic [PC_W-1:0] upd_pc,
   input logic [PC_W-1:0] upd_target
);

   logic            stores;
   logic            seen_store;
   logic [PC_W-1:0] kept_tgt;

   assign stores = upd_en && (upd_kind == 2'b01 || upd_kind == 2'b10);
   assign kept_tgt = DROP_TGT_OFS ?
                     (upd_target & ~PC_W'((1 << OFS_W) - 1)) : upd_target;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_store <= 1'b0;
      else if (stores) seen_store <= 1'b1;
   end

   // R1: nothing hits before the first insertion since reset.
   p_cold_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_store |-> !pred_hit);

   // R4: a miss yields the sequential address.
   p_miss_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (pred_pc == fetch_pc + PC_W'(INSN_BYTES)));

   // R3, R7: an insertion is seen by a lookup of that PC on the next cycle.
   p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stores |=> ((fetch_pc != $past(upd_pc)) ||
                  (pred_hit && pred_pc == $past(kept_tgt))));

   // R6: after an insertion, another tag in the same slot misses.
   p_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stores |=> ((fetch_pc[OFS_W +: IDX_W] != $past(upd_pc[OFS_W +: IDX_W])) ||
                  (fetch_pc[PC_W-1:OFS_W+IDX_W] == $past(upd_pc[PC_W-1:OFS_W+IDX_W])) ||
                  !pred_hit));

   // R5: a cycle with no storable update leaves the prediction for a held PC alone.
   p_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !stores |=> (!$stable(fetch_pc) || ($stable(pred_hit) && $stable(pred_pc))));

endmodule

bind branch_tgt_buf btbt_checker #(
   .PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W),
   .INSN_BYTES(INSN_BYTES), .DROP_TGT_OFS(DROP_TGT_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_pc(pred_pc),
   .pred_hit(pred_hit), .upd_en(upd_en), .upd_kind(upd_kind),
   .upd_pc(upd_pc), .upd_target(upd_target)
);

// File: tb/branch_tgt_buf_bench.sv
module branch_tgt_buf_bench;

   localparam int PC_W = 32;
   localparam int IDX_W = 6;
   localparam int OFS_W = 2;
   localparam int STEP = 4;
   localparam int LOWB = IDX_W + OFS_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic [PC_W-1:0] pred_pc;
   logic            pred_hit;
   logic            upd_en = 1'b0;
   logic [1:0]      upd_kind = 2'b00;
   logic [PC_W-1:0] upd_pc = '0;
   logic [PC_W-1:0] upd_target = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Behavioural reference: slot number -> full PC and target last stored there.
   logic [PC_W-1:0] ref_pc [int];
   logic [PC_W-1:0] ref_tgt [int];

   always #2 clk = ~clk;

   branch_tgt_buf #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W),
                    .INSN_BYTES(STEP), .DROP_TGT_OFS(1'b1)) u_branch_tgt_buf (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_pc(pred_pc),
      .pred_hit(pred_hit), .upd_en(upd_en), .upd_kind(upd_kind),
      .upd_pc(upd_pc), .upd_target(upd_target)
   );

   function automatic int slot_of(logic [PC_W-1:0] a);
      return int'((a >> OFS_W) & ((1 << IDX_W) - 1));
   endfunction

   task automatic check(string rq, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, compare, then let the edge commit.
   task automatic cycle(string rq, logic [PC_W-1:0] pc, logic en, logic [1:0] kind,
                        logic [PC_W-1:0] upc, logic [PC_W-1:0] utgt);
      int s;
      logic exp_hit;
      logic [PC_W-1:0] exp_pc;
      @(negedge clk);
      fetch_pc = pc; upd_en = en; upd_kind = kind; upd_pc = upc; upd_target = utgt;
      #1;
      s = slot_of(pc);
      exp_hit = ref_pc.exists(s) && ((ref_pc[s] >> LOWB) == (pc >> LOWB));
      exp_pc = exp_hit ? ref_tgt[s] : pc + STEP;
      check({rq, " hit"}, PC_W'(pred_hit), PC_W'(exp_hit));
      check({rq, " pc"}, pred_pc, exp_pc);
      @(posedge clk);
      if (rst_n && en && (kind == 2'b01 || kind == 2'b10)) begin
         ref_pc[slot_of(upc)] = upc;
         ref_tgt[slot_of(upc)] = utgt & ~32'h3;
      end
   endtask

   task automatic look(string rq, logic [PC_W-1:0] pc);
      cycle(rq, pc, 1'b0, 2'b00, '0, '0);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [PC_W-1:0] pool [8];
      pool[0] = 32'h0000_0100; pool[1] = 32'h0000_1100; pool[2] = 32'h0000_0204;
      pool[3] = 32'h0000_2204; pool[4] = 32'h0000_0308; pool[5] = 32'h0000_030C;
      pool[6] = 32'hFFFF_FFFC; pool[7] = 32'h0000_04FC;

      // R1: outputs while held in reset.
      @(negedge clk); fetch_pc = 32'h0000_0100; #1;
      check("R1 reset hit", PC_W'(pred_hit), '0);
      check("R1 reset pc", pred_pc, 32'h0000_0104);
      @(negedge clk); rst_n = 1'b1;

      look("R1 cold", 32'h0000_0100);
      look("R4 wrap", 32'hFFFF_FFFC);
      // R7: same-cycle lookup sees the old (empty) slot, then R3 hit.
      cycle("R7 same cycle", 32'h0000_0100, 1'b1, 2'b01, 32'h0000_0100, 32'h0000_0040);
      look("R3 branch hit", 32'h0000_0100);
      // R8 / R2: offset bits ignored.
      look("R8 offset", 32'h0000_0103);
      // Direct jump into a neighbouring slot; R9 others unchanged.
      cycle("R3 jump", 32'h0000_0100, 1'b1, 2'b10, 32'h0000_0204, 32'h0000_0800);
      look("R3 jump hit", 32'h0000_0204);
      look("R9 neighbour", 32'h0000_0100);
      // R5: plain and indirect kinds never stored.
      cycle("R5 plain", 32'h0000_0308, 1'b1, 2'b00, 32'h0000_0308, 32'h0000_0900);
      look("R5 plain look", 32'h0000_0308);
      cycle("R5 indirect", 32'h0000_030C, 1'b1, 2'b11, 32'h0000_030C, 32'h0000_0A00);
      look("R5 indirect look", 32'h0000_030C);
      cycle("R5 disabled", 32'h0000_0308, 1'b0, 2'b01, 32'h0000_0308, 32'h0000_0B00);
      look("R5 disabled look", 32'h0000_0308);
      // R6: alias with a different tag replaces the slot.
      look("R2 alias before", 32'h0000_1100);
      cycle("R6 alias write", 32'h0000_1100, 1'b1, 2'b01, 32'h0000_1100, 32'h0000_0C00);
      look("R6 new owner", 32'h0000_1100);
      look("R6 old evicted", 32'h0000_0100);
      look("R9 jump kept", 32'h0000_0204);

      // Mixed traffic compared every cycle.
      for (int i = 0; i < 400; i++) begin
         logic [PC_W-1:0] fpc, upc;
         fpc = pool[$urandom_range(0, 7)] | PC_W'($urandom_range(0, 3));
         upc = pool[$urandom_range(0, 7)];
         cycle("R3 R4 R5 mixed", fpc, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
               upc, PC_W'($urandom) & ~32'h3);
      end

      // R1: a second reset empties every slot.
      @(negedge clk); rst_n = 1'b0; upd_en = 1'b0;
      ref_pc.delete(); ref_tgt.delete();
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 8; i++) look("R1 after reset", pool[i]);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule